// File: doc/BRIEF.md
# Configuration Access Bridge

This block connects a processor's I/O port accesses to a configuration-space back end on a single bus. It implements the classic indirect scheme: software first writes a 32-bit selector into an address register at one group of four ports. It then reads or writes a four-port data window, and that window is forwarded as configuration-space traffic to the device, function and register the selector names.

Data-window accesses are replayed toward the back end one byte per cycle. Each byte carries an 8-bit slot key and an 8-bit byte offset. The back end answers combinationally in the same cycle with a present flag, the header-type byte of the addressed function and the read byte. Writes are filtered per byte through a fixed writability map. Command-byte writes produce an enable strobe, and writes to the BIST byte store zero. Expansion-ROM writes and completed writes each produce a strobe when the access ends.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the address register reads as zero. The address register answers at ports 0xCF8–0xCFB and the data window at ports 0xCFC–0xCFF, with port bits [1:0] as the byte lane. Selector bit 31 is stored but does not affect decoding. The selector fields are bus [23:16], device [15:11], function [10:8] and register [7:2].
- R2: An address-register access whose lane plus length exceeds four is rejected: cpu_err is set with cpu_done, the read data is zero, and the register is unchanged. This rejects a 4-byte access off lane 0 and a 2-byte access at lane 3.
- R3: A legal address-register write replaces bytes lane..lane+len-1 with the low bytes of cpu_wdata. A legal read returns those bytes in the low bytes of cpu_rdata, with the upper bytes zero. Either access completes one cycle after acceptance.
- R4: A data-window access on bus 0 issues len consecutive cycles of cfg_req. cfg_slot is device×8+function. cfg_offset starts at register×4+lane and rises by one per byte. cpu_done follows len+1 cycles after acceptance.
- R5: When the bus field is non-zero, a read returns 0xFF in every requested byte and a write is discarded. No cfg_req is issued, and the access completes in one cycle.
- R6: If cfg_present is low for the addressed slot, every requested read byte is 0xFF and no write byte is committed.
- R7: A write byte is committed (cfg_we) only for header type 0x00 or 0x80 and a writable offset. The writable offsets are 0x04–0x05, 0x0C, 0x0D, 0x0F, 0x10–0x27, 0x30–0x33, 0x3C and 0x40–0xFF. Any other offset, or any other header type, keeps its value.
- R8: A committed write at offset 0x04 pulses cmd_strobe for one cycle, with cmd_io_en equal to data bit 0 and cmd_mem_en equal to data bit 1.
- R9: A committed write at offset 0x0F stores 0x00 whatever data was written.
- R10: If any byte at offsets 0x30–0x33 was committed, rom_strobe pulses in the cycle the access completes.
- R11: A data-window write on bus 0 to a present slot pulses upd_strobe with cpu_done, carrying the starting offset and the length.
- R12: A length other than 1, 2 or 4, or a port outside both windows, completes in one cycle with cpu_err and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is high |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_port | input | 16 | I/O port address |
| cpu_len | input | 3 | Byte count (1, 2 or 4) |
| cpu_wdata | input | 32 | Write data, first byte in bits [7:0] |
| cpu_ready | output | 1 | Bridge can accept an access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Access rejected (valid with cpu_done) |
| cpu_rdata | output | 32 | Read data (valid with cpu_done) |
| cfg_req | output | 1 | Configuration byte cycle active |
| cfg_slot | output | 8 | Device×8+function key |
| cfg_offset | output | 8 | Byte offset in configuration space |
| cfg_we | output | 1 | Commit cfg_wdata at cfg_offset |
| cfg_wdata | output | 8 | Byte to store |
| cfg_present | input | 1 | Addressed slot holds a device |
| cfg_hdr | input | 8 | Header type of addressed slot |
| cfg_rdata | input | 8 | Byte read at cfg_offset |
| cmd_strobe | output | 1 | Command byte written |
| cmd_io_en | output | 1 | I/O decode enable from last command write |
| cmd_mem_en | output | 1 | Memory decode enable from last command write |
| rom_strobe | output | 1 | Expansion-ROM base written |
| upd_strobe | output | 1 | Data-window write completed |
| upd_offset | output | 8 | Starting offset of that write |
| upd_len | output | 3 | Length of that write |

## Verification
The hardest situation to reach is a single multi-byte write that mixes committed, filtered and rewritten bytes. One example is a 4-byte write at offset 0x0C, where 0x0C and 0x0D are stored, 0x0E is read-only and 0x0F is forced to zero. Reaching it takes a sequence of selector writes followed by data-window writes at chosen lanes. The bench then reads the result back through the data window. A behavioural model of configuration memory, selector and strobes is stepped alongside every access, and it predicts the offset and slot of each back-end cycle as well as the final bytes. The same sequence also reaches slots with a non-writable header type, absent slots and a non-zero bus, so that filtering is checked through read-back rather than by inspecting internals.

// File: rtl/cab_pkg.sv
package cab_pkg;

  localparam logic [7:0] HDR_PLAIN   = 8'h00;
  localparam logic [7:0] HDR_MULTIFN = 8'h80;
  localparam logic [7:0] OFF_COMMAND = 8'h04;
  localparam logic [7:0] OFF_SELFTST = 8'h0F;

  // Offsets a write may commit, for the two supported header layouts.
  function automatic logic cfg_byte_writable(input logic [7:0] hdr, input logic [7:0] off);
    logic ok;
    if ((hdr != HDR_PLAIN) && (hdr != HDR_MULTIFN)) begin
      ok = 1'b0;
    end else begin
      ok = (off >= 8'h40) ||
           ((off >= 8'h10) && (off <= 8'h27)) ||
           ((off >= 8'h30) && (off <= 8'h33)) ||
           (off == 8'h04) || (off == 8'h05) || (off == 8'h0C) ||
           (off == 8'h0D) || (off == 8'h0F) || (off == 8'h3C);
    end
    return ok;
  endfunction

  function automatic logic is_rom_base(input logic [7:0] off);
    return (off >= 8'h30) && (off <= 8'h33);
  endfunction

endpackage

// File: rtl/cab_addr_reg.sv
module cab_addr_reg #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [LANE_W-1:0] lane,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic              legal,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] rd
);
  localparam int LANES = DATA_W / 8;

  logic              len_ok;
  logic [DATA_W-1:0] wshift;
  logic [DATA_W-1:0] rmask;

  always_comb begin
    len_ok = (len != '0) && ((len & (len - LEN_W'(1))) == '0) && (int'(len) <= LANES);
    legal  = len_ok && ((int'(lane) + int'(len)) <= LANES);
    wshift = wdata << {lane, 3'b000};
    for (int b = 0; b < LANES; b++) begin
      rmask[b*8 +: 8] = (b < int'(len)) ? 8'hFF : 8'h00;
    end
    rd = (q >> {lane, 3'b000}) & rmask;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    logic sel;
    assign sel = acc && acc_wr && legal &&
                 (b >= int'(lane)) && (b < (int'(lane) + int'(len)));
    always_ff @(posedge clk) begin
      if (rst)      q[b*8 +: 8] <= 8'h00;
      else if (sel) q[b*8 +: 8] <= wshift[b*8 +: 8];
    end
  end

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !legal) |=> $stable(q));

endmodule

// File: rtl/cab_data_seq.sv
module cab_data_seq
  import cab_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 8,
  parameter int SLOT_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic              bus_nz,
  input  logic [OFF_W-1:0]  start_off,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cfg_req,
  output logic [SLOT_W-1:0] cfg_slot,
  output logic [OFF_W-1:0]  cfg_offset,
  output logic              cfg_we,
  output logic [7:0]        cfg_wdata,
  input  logic              cfg_present,
  input  logic [7:0]        cfg_hdr,
  input  logic [7:0]        cfg_rdata,
  output logic              cmd_strobe,
  output logic              cmd_io_en,
  output logic              cmd_mem_en,
  output logic              rom_strobe,
  output logic              upd_strobe,
  output logic [OFF_W-1:0]  upd_offset,
  output logic [LEN_W-1:0]  upd_len
);
  localparam int LANES = DATA_W / 8;

  logic              busy_q, wr_q, hit_q, rom_seen_q;
  logic [LEN_W-1:0]  idx_q, len_q;
  logic [OFF_W-1:0]  base_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [OFF_W-1:0]  cur_off;
  logic [7:0]        cur_byte;
  logic              last, byte_we, byte_rom;
  logic [DATA_W-1:0] ff_mask;

  always_comb begin
    cur_off  = base_q + {{(OFF_W-LEN_W){1'b0}}, idx_q};
    cur_byte = wdata_q[int'(idx_q)*8 +: 8];
    last     = (idx_q == (len_q - LEN_W'(1)));
    byte_we  = busy_q && wr_q && cfg_present && cfg_byte_writable(cfg_hdr, cur_off);
    byte_rom = byte_we && is_rom_base(cur_off);
    for (int b = 0; b < LANES; b++) begin
      ff_mask[b*8 +: 8] = (b < int'(start_len)) ? 8'hFF : 8'h00;
    end
  end

  assign busy       = busy_q;
  assign rdata      = rdata_q;
  assign cfg_req    = busy_q;
  assign cfg_slot   = slot_q;
  assign cfg_offset = cur_off;
  assign cfg_we     = byte_we;
  assign cfg_wdata  = (cur_off == OFF_SELFTST) ? 8'h00 : cur_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; wr_q <= 1'b0; hit_q <= 1'b0; rom_seen_q <= 1'b0;
      idx_q <= '0; len_q <= '0; base_q <= '0; slot_q <= '0;
      wdata_q <= '0; rdata_q <= '0;
      done <= 1'b0; cmd_strobe <= 1'b0; cmd_io_en <= 1'b0; cmd_mem_en <= 1'b0;
      rom_strobe <= 1'b0; upd_strobe <= 1'b0; upd_offset <= '0; upd_len <= '0;
    end else begin
      done       <= 1'b0;
      cmd_strobe <= 1'b0;
      rom_strobe <= 1'b0;
      upd_strobe <= 1'b0;
      if (start && !busy_q) begin
        wr_q       <= start_wr;
        len_q      <= start_len;
        base_q     <= start_off;
        slot_q     <= start_slot;
        wdata_q    <= start_wdata;
        idx_q      <= '0;
        hit_q      <= 1'b0;
        rom_seen_q <= 1'b0;
        if (bus_nz) begin
          done    <= 1'b1;
          rdata_q <= start_wr ? '0 : ff_mask;
        end else begin
          busy_q  <= 1'b1;
          rdata_q <= '0;
        end
      end else if (busy_q) begin
        if (!wr_q) rdata_q[int'(idx_q)*8 +: 8] <= cfg_present ? cfg_rdata : 8'hFF;
        if (cfg_present) hit_q <= 1'b1;
        if (byte_rom)    rom_seen_q <= 1'b1;
        if (byte_we && (cur_off == OFF_COMMAND)) begin
          cmd_strobe <= 1'b1;
          cmd_io_en  <= cur_byte[0];
          cmd_mem_en <= cur_byte[1];
        end
        if (last) begin
          busy_q     <= 1'b0;
          done       <= 1'b1;
          rom_strobe <= rom_seen_q || byte_rom;
          upd_strobe <= wr_q && (hit_q || cfg_present);
          upd_offset <= base_q;
          upd_len    <= len_q;
        end else begin
          idx_q <= idx_q + LEN_W'(1);
        end
      end
    end
  end

  // R4
  offset_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (cfg_req && (cfg_offset == $past(cfg_offset) + OFF_W'(1))));

  // R8
  cmd_source_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> ($past(cfg_we) && ($past(cfg_offset) == OFF_COMMAND)));

  // R10
  rom_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    rom_strobe |-> (done && upd_strobe));

  // R11
  upd_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> (done && !busy_q));

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
  parameter int          PORT_W    = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter int          DATA_W    = 32,
  parameter int          OFF_W     = 8,
  parameter int          SLOT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [PORT_W-1:0] cpu_port,
  input  logic [2:0]        cpu_len,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_err,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cfg_req,
  output logic [SLOT_W-1:0] cfg_slot,
  output logic [OFF_W-1:0]  cfg_offset,
  output logic              cfg_we,
  output logic [7:0]        cfg_wdata,
  input  logic              cfg_present,
  input  logic [7:0]        cfg_hdr,
  input  logic [7:0]        cfg_rdata,
  output logic              cmd_strobe,
  output logic              cmd_io_en,
  output logic              cmd_mem_en,
  output logic              rom_strobe,
  output logic              upd_strobe,
  output logic [OFF_W-1:0]  upd_offset,
  output logic [2:0]        upd_len
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int LEN_W  = 3;

  logic              accept, hit_addr, hit_data, len_ok, legal, seq_start, bus_nz;
  logic              seq_busy, seq_done;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] sel_q, sel_rd, seq_rdata;
  logic [OFF_W-1:0]  base_off;
  logic [SLOT_W-1:0] slot_key;
  logic              a_done_q, a_err_q;
  logic [DATA_W-1:0] a_rdata_q;
  logic              unused_sel;

  assign lane      = cpu_port[LANE_W-1:0];
  assign hit_addr  = cpu_port[PORT_W-1:LANE_W] == ADDR_PORT[PORT_W-1:LANE_W];
  assign hit_data  = cpu_port[PORT_W-1:LANE_W] == DATA_PORT[PORT_W-1:LANE_W];
  assign len_ok    = (cpu_len != 3'd0) && ((cpu_len & (cpu_len - 3'd1)) == 3'd0) &&
                     (int'(cpu_len) <= LANES);
  assign cpu_ready = !seq_busy;
  assign accept    = cpu_req && cpu_ready;
  assign seq_start = accept && hit_data && len_ok;
  assign bus_nz    = sel_q[23:16] != 8'h00;
  assign base_off  = {sel_q[7:2], 2'b00} + OFF_W'(lane);
  assign slot_key  = {sel_q[15:11], sel_q[10:8]};
  assign unused_sel = ^{sel_q[31:24], sel_q[1:0]};

  cab_addr_reg #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEN_W(LEN_W)) u_sel (
    .clk(clk), .rst(rst), .acc(accept && hit_addr), .acc_wr(cpu_wr),
    .lane(lane), .len(cpu_len), .wdata(cpu_wdata),
    .legal(legal), .q(sel_q), .rd(sel_rd)
  );

  cab_data_seq #(.DATA_W(DATA_W), .OFF_W(OFF_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .start_wr(cpu_wr), .bus_nz(bus_nz),
    .start_off(base_off), .start_slot(slot_key), .start_len(cpu_len), .start_wdata(cpu_wdata),
    .busy(seq_busy), .done(seq_done), .rdata(seq_rdata),
    .cfg_req(cfg_req), .cfg_slot(cfg_slot), .cfg_offset(cfg_offset), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_present(cfg_present), .cfg_hdr(cfg_hdr), .cfg_rdata(cfg_rdata),
    .cmd_strobe(cmd_strobe), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
    .rom_strobe(rom_strobe), .upd_strobe(upd_strobe), .upd_offset(upd_offset), .upd_len(upd_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_done_q  <= 1'b0;
      a_err_q   <= 1'b0;
      a_rdata_q <= '0;
    end else begin
      a_done_q  <= accept && !seq_start;
      a_err_q   <= accept && !(hit_addr && legal) && !seq_start;
      a_rdata_q <= (accept && hit_addr && legal && !cpu_wr) ? sel_rd : '0;
    end
  end

  assign cpu_done  = a_done_q | seq_done;
  assign cpu_err   = a_done_q & a_err_q;
  assign cpu_rdata = seq_done ? seq_rdata : a_rdata_q;

  // R12
  stray_port_err_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_addr && !hit_data) |=> (cpu_done && cpu_err));

  // R5
  busnz_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_start && bus_nz) |=> (cpu_done && !cfg_req));

endmodule

// File: tb/tb_cfg_access_bridge.sv
`timescale 1ns/1ps
module tb_cfg_access_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_port = '0;
  logic [2:0]  cpu_len = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_done, cpu_err;
  logic [31:0] cpu_rdata;
  logic        cfg_req, cfg_we, cfg_present;
  logic [7:0]  cfg_slot, cfg_offset, cfg_wdata, cfg_hdr, cfg_rdata;
  logic        cmd_strobe, cmd_io_en, cmd_mem_en, rom_strobe, upd_strobe;
  logic [7:0]  upd_offset;
  logic [2:0]  upd_len;

  always #4 clk = ~clk;

  cfg_access_bridge dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_port(cpu_port),
    .cpu_len(cpu_len), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_err(cpu_err), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req), .cfg_slot(cfg_slot),
    .cfg_offset(cfg_offset), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_present(cfg_present),
    .cfg_hdr(cfg_hdr), .cfg_rdata(cfg_rdata), .cmd_strobe(cmd_strobe), .cmd_io_en(cmd_io_en),
    .cmd_mem_en(cmd_mem_en), .rom_strobe(rom_strobe), .upd_strobe(upd_strobe),
    .upd_offset(upd_offset), .upd_len(upd_len)
  );

  int total = 0, fails = 0;

  // device model: three present slots
  logic [7:0] dmem [3][256];
  logic [7:0] emem [3][256];

  function automatic int dev_idx(input logic [7:0] slot);
    case (slot)
      8'h08:   return 0;  // device 1 function 0
      8'h11:   return 1;  // device 2 function 1
      8'h1A:   return 2;  // device 3 function 2
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] hdr_of(input int d);
    if (d == 0) return 8'h00;
    if (d == 1) return 8'h80;
    return 8'h01;
  endfunction

  function automatic bit ref_writable(input logic [7:0] hdr, input int off);
    if (!(hdr == 8'h00 || hdr == 8'h80)) return 1'b0;
    if (off inside {4, 5, 12, 13, 15, 60}) return 1'b1;
    if (off >= 16 && off < 40) return 1'b1;
    if (off >= 48 && off < 52) return 1'b1;
    return off >= 64;
  endfunction

  always_comb begin
    int d;
    d = dev_idx(cfg_slot);
    cfg_present = (d >= 0);
    cfg_hdr     = (d >= 0) ? hdr_of(d) : 8'hFF;
    cfg_rdata   = (d >= 0) ? dmem[d][cfg_offset] : 8'h00;
  end

  always @(posedge clk) begin
    int d;
    d = dev_idx(cfg_slot);
    if (cfg_we && d >= 0) dmem[d][cfg_offset] <= cfg_wdata;
  end

  // reference state
  logic [31:0] exp_sel = '0;
  int exp_base = 0, exp_slot = 0;
  int m_k = 0, m_cmd = 0, m_rom = 0, m_upd = 0, m_we = 0, m_uoff = 0, m_ulen = 0;
  bit m_io = 0, m_mem = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_strobe) begin m_cmd++; m_io = cmd_io_en; m_mem = cmd_mem_en; end
      if (rom_strobe) m_rom++;
      if (upd_strobe) begin m_upd++; m_uoff = upd_offset; m_ulen = upd_len; end
      if (cfg_we) m_we++;
      if (cfg_req) begin
        chk("R4", 32'(cfg_slot), 32'(exp_slot), "slot key");
        chk("R4", 32'(cfg_offset), 32'((exp_base + m_k) & 255), "byte offset");
        m_k++;
      end
    end
  end

  task automatic run(input string tag, input bit wr, input logic [15:0] port, input int len,
                     input logic [31:0] wd);
    logic [31:0] e_rd;
    bit e_err, e_io, e_mem;
    int e_lat, e_cmd, e_rom, e_upd, e_we, e_uoff, e_ulen, lane, lat;
    bit in_a, in_d, lok;
    e_rd = '0; e_err = 0; e_io = 0; e_mem = 0;
    e_lat = 1; e_cmd = 0; e_rom = 0; e_upd = 0; e_we = 0; e_uoff = 0; e_ulen = 0;
    lane = int'(port[1:0]);
    in_a = (port[15:2] == 14'h33E);
    in_d = (port[15:2] == 14'h33F);
    lok  = (len == 1) || (len == 2) || (len == 4);
    if (!lok || (!in_a && !in_d)) begin
      e_err = 1;
    end else if (in_a) begin
      if (lane + len > 4) e_err = 1;
      else begin
        for (int i = 0; i < len; i++) begin
          if (wr) exp_sel[(lane+i)*8 +: 8] = wd[i*8 +: 8];
          else    e_rd[i*8 +: 8] = exp_sel[(lane+i)*8 +: 8];
        end
      end
    end else begin
      int bus, d;
      bus = int'(exp_sel[23:16]);
      exp_slot = int'(exp_sel[15:8]);
      exp_base = (int'(exp_sel[7:2]) * 4 + lane) & 255;
      d = dev_idx(exp_sel[15:8]);
      if (bus != 0) begin
        if (!wr) for (int i = 0; i < len; i++) e_rd[i*8 +: 8] = 8'hFF;
      end else begin
        e_lat = len + 1;
        for (int i = 0; i < len; i++) begin
          int off;
          logic [7:0] v;
          off = (exp_base + i) & 255;
          if (!wr) e_rd[i*8 +: 8] = (d < 0) ? 8'hFF : emem[d][off];
          else if (d >= 0 && ref_writable(hdr_of(d), off)) begin
            v = (off == 15) ? 8'h00 : wd[i*8 +: 8];
            emem[d][off] = v;
            e_we++;
            if (off == 4) begin e_cmd++; e_io = v[0]; e_mem = v[1]; end
            if (off >= 48 && off < 52) e_rom = 1;
          end
        end
        if (wr && d >= 0) begin e_upd = 1; e_uoff = exp_base; e_ulen = len; end
      end
    end
    m_k = 0; m_cmd = 0; m_rom = 0; m_upd = 0; m_we = 0;
    cpu_req = 1'b1; cpu_wr = wr; cpu_port = port; cpu_len = 3'(len); cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_done && lat < 20) begin @(negedge clk); lat++; end
    chk(tag, 32'(cpu_err), 32'(e_err), "error flag");
    chk(tag, cpu_rdata, e_rd, "read data");
    chk(tag, 32'(lat), 32'(e_lat), "latency");
    #1;
    chk(tag, 32'(m_we), 32'(e_we), "committed bytes");
    chk("R8", 32'(m_cmd), 32'(e_cmd), "command strobes");
    if (e_cmd > 0) chk("R8", {30'd0, m_mem, m_io}, {30'd0, e_mem, e_io}, "enable bits");
    chk("R10", 32'(m_rom), 32'(e_rom), "rom strobes");
    chk("R11", 32'(m_upd), 32'(e_upd), "update strobes");
    if (e_upd > 0) chk("R11", 32'((m_uoff << 8) | m_ulen), 32'((e_uoff << 8) | e_ulen), "update off/len");
  endtask

  function automatic logic [31:0] sel(input int bus, input int dv, input int fn, input int rg);
    return {1'b1, 7'd0, 8'(bus), 5'(dv), 3'(fn), 6'(rg), 2'b00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++)
      for (int o = 0; o < 256; o++) begin
        dmem[d][o] = 8'((d * 37 + o) ^ 8'h5A);
        emem[d][o] = 8'((d * 37 + o) ^ 8'h5A);
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {29'd0, cpu_ready, cpu_done, cfg_req}, 32'h4, "idle after reset");
    run("R1", 0, 16'h0CF8, 4, 0);
    run("R3", 1, 16'h0CF8, 4, sel(0, 1, 0, 0));
    run("R3", 0, 16'h0CF8, 4, 0);
    run("R3", 0, 16'h0CFB, 1, 0);
    run("R3", 0, 16'h0CF9, 2, 0);
    run("R2", 1, 16'h0CF9, 4, 32'hFFFF_FFFF);
    run("R2", 1, 16'h0CFB, 2, 32'hFFFF_FFFF);
    run("R2", 0, 16'h0CFA, 4, 0);
    run("R2", 0, 16'h0CF8, 4, 0);
    run("R4", 0, 16'h0CFC, 4, 0);
    run("R4", 0, 16'h0CFD, 1, 0);
    run("R4", 0, 16'h0CFE, 2, 0);
    run("R7", 1, 16'h0CFC, 4, 32'h1234_5678);
    run("R7", 0, 16'h0CFC, 4, 0);
    run("R8", 1, 16'h0CF8, 4, sel(0, 1, 0, 1));
    run("R8", 1, 16'h0CFC, 2, 32'h0000_0003);
    run("R8", 1, 16'h0CFC, 1, 32'h0000_0002);
    run("R8", 0, 16'h0CFC, 4, 0);
    run("R9", 1, 16'h0CF8, 4, sel(0, 1, 0, 3));
    run("R9", 1, 16'h0CFC, 4, 32'hAABB_CCDD);
    run("R9", 0, 16'h0CFC, 4, 0);
    run("R1", 1, 16'h0CFB, 1, 32'h0000_0000);
    run("R1", 0, 16'h0CFC, 4, 0);
    run("R10", 1, 16'h0CF8, 4, sel(0, 1, 0, 12));
    run("R10", 1, 16'h0CFE, 1, 32'h0000_0055);
    run("R10", 1, 16'h0CFC, 4, 32'h0102_0304);
    run("R10", 0, 16'h0CFC, 4, 0);
    run("R7", 1, 16'h0CF8, 4, sel(0, 1, 0, 4));
    run("R7", 1, 16'h0CFC, 4, 32'hDEAD_BEEF);
    run("R7", 0, 16'h0CFC, 4, 0);
    run("R7", 1, 16'h0CF8, 4, sel(0, 1, 0, 15));
    run("R7", 1, 16'h0CFC, 2, 32'h0000_A5C3);
    run("R7", 0, 16'h0CFC, 4, 0);
    run("R7", 1, 16'h0CF8, 4, sel(0, 2, 1, 15));
    run("R7", 1, 16'h0CFC, 4, 32'h7766_5544);
    run("R7", 0, 16'h0CFC, 4, 0);
    run("R7", 1, 16'h0CF8, 4, sel(0, 3, 2, 1));
    run("R7", 1, 16'h0CFC, 1, 32'h0000_0007);
    run("R7", 0, 16'h0CFC, 4, 0);
    run("R11", 1, 16'h0CF8, 4, sel(0, 1, 0, 63));
    run("R11", 1, 16'h0CFF, 1, 32'h0000_00E1);
    run("R11", 0, 16'h0CFF, 1, 0);
    run("R6", 1, 16'h0CF8, 4, sel(0, 5, 0, 1));
    run("R6", 0, 16'h0CFC, 4, 0);
    run("R6", 1, 16'h0CFC, 2, 32'h0000_0003);
    run("R5", 1, 16'h0CF8, 4, sel(1, 1, 0, 1));
    run("R5", 0, 16'h0CFE, 2, 0);
    run("R5", 1, 16'h0CFC, 4, 32'h0000_0000);
    run("R12", 0, 16'h0CFC, 3, 0);
    run("R12", 1, 16'h0CF8, 0, 32'h1111_1111);
    run("R12", 0, 16'h0080, 1, 0);
    run("R12", 0, 16'h0CF8, 4, 0);
    run("R5", 1, 16'h0CF8, 4, sel(0, 1, 0, 1));
    run("R5", 0, 16'h0CFC, 4, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule